// File: doc/BRIEF.md
# I2C Slave With Four Programmable Addresses

This block is the target side of a two-wire serial bus port. It oversamples the clock and data lines with the system clock, recognises start and stop conditions, and collects the first byte that follows a start. The upper seven bits of that byte are compared against four software-programmed identity registers. If any of them matches, the slave pulls the data line low during the ninth clock. If none matches, it stays silent until the next start.

After a match, bit 0 of the address byte selects the direction. When it is 0, the master writes bytes into a small receive FIFO. When it is 1, the slave shifts bytes out of a small transmit FIFO, MSB first. A simple strobe-based register port gives access to the identity registers, the two FIFOs and a read-only status byte.

The same channel can also be handed to a master engine, which is outside this block. While master mode is selected, the slave ignores the bus. A flush request from the master side empties the slave receive FIFO.

Top module: `i2c_quad_id_slave`

## Requirements
- R1: When the upper seven bits of the address byte equal bits 7:1 of any of the four identity registers, the slave drives SDA low for the ninth SCL pulse (ACK).
- R2: Bit 0 of each identity register takes no part in the comparison. A register holding 0xA3 therefore matches the address bytes 0xA2 and 0xA3.
- R3: When no identity register matches, SDA stays released during the acknowledge bit and for every later bit until the next start, and no byte enters the receive FIFO.
- R4: A write to an identity register while a transfer is in progress is ignored. A write while the bus is idle takes effect and reads back unchanged.
- R5: The status register resets to 0x01 and is read-only. Its bits are: 0 = transmit FIFO empty, 1 = receive data available, 2 = transfer in progress, 3 = stop seen, 4 = last match was a read, 5 = transmit FIFO full.
- R6: While master_mode_i is high, the slave never drives SDA and does not record stop conditions.
- R7: A pulse on rx_flush_i empties the receive FIFO, so status bit 1 reads 0 afterwards.
- R8: In a write transfer, each data byte is acknowledged and pushed into the receive FIFO. The bytes are popped in arrival order by reads of address 5.
- R9: In a read transfer, bytes written to address 4 are sent MSB first. An empty transmit FIFO sends 0xFF. A master NACK ends the read, and SDA stays released for any further clocks.
- R10: A stop condition returns the slave to idle (status bit 2 = 0) and sets status bit 3. Reading the status register clears bit 3.
- R11: Register map on reg_addr_i: 0 to 3 are the identity registers (read/write), 4 pushes transmit data, 5 pops receive data, 6 is status, and 7 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the pad |
| sda_i | input | 1 | Serial data line as seen on the pad |
| sda_oe_o | output | 1 | High pulls the data line low (open drain) |
| master_mode_i | input | 1 | Channel is owned by the master engine |
| rx_flush_i | input | 1 | Flush request that empties the receive FIFO |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (pops FIFO, clears stop flag) |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational on reg_addr_i |

## Verification
The assertions assume that SCL and SDA change only slowly compared with the system clock, so that each level lasts several cycles after synchronisation. They also assume that master_mode_i is a quasi-static configuration input. The bench drives both lines as an ideal open-drain master whose quarter-bit is ten system clocks. It changes data only while SCL is low, except at deliberate start and stop conditions. It moves master_mode_i only while the bus is idle. Register strobes are driven as single-cycle pulses placed on falling clock edges.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_RX, ST_RACK, ST_TX, ST_TACK, ST_IGNORE
  } i2cs_state_e;

  localparam logic [2:0] A_TXD  = 3'd4;
  localparam logic [2:0] A_RXD  = 3'd5;
  localparam logic [2:0] A_STAT = 3'd6;
endpackage

// File: rtl/i2cs_linemon.sv
module i2cs_linemon #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic [SYNC:0] scl_sh, sda_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[SYNC-1:0], scl_i};
      sda_sh <= {sda_sh[SYNC-1:0], sda_i};
    end
  end

  logic scl_now, scl_old, sda_old;
  assign scl_now  = scl_sh[SYNC-1];
  assign scl_old  = scl_sh[SYNC];
  assign sda_s    = sda_sh[SYNC-1];
  assign sda_old  = sda_sh[SYNC];
  assign scl_rise = scl_now & ~scl_old;
  assign scl_fall = ~scl_now & scl_old;
  assign start_p  = scl_now & scl_old & sda_old & ~sda_s;
  assign stop_p   = scl_now & scl_old & ~sda_old & sda_s;
endmodule

// File: rtl/i2cs_idmatch.sv
module i2cs_idmatch #(
  parameter int N_IDS = 4
) (
  input  logic [N_IDS*8-1:0] ids,
  input  logic [6:0]         addr7,
  output logic               hit
);
  logic [N_IDS-1:0] eq;
  for (genvar i = 0; i < N_IDS; i++) begin : g_cmp
    assign eq[i] = (ids[i*8+7 -: 7] == addr7);
  end
  assign hit = |eq;
endmodule

// File: rtl/i2cs_fifo.sv
module i2cs_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push & ~full & ~flush;
  assign do_pop  = pop & ~empty & ~flush;
  assign rdata   = mem[rp];

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= inc(wp);
      if (do_pop)  rp <= inc(rp);
      if (do_push != do_pop) cnt <= do_push ? cnt + CW'(1) : cnt - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end
endmodule

// File: rtl/i2c_quad_id_slave.sv
module i2c_quad_id_slave
  import i2cs_pkg::*;
#(
  parameter int N_IDS    = 4,
  parameter int FIFO_DEP = 4,
  parameter int SYNC     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic       master_mode_i,
  input  logic       rx_flush_i,
  input  logic       reg_wr_i,
  input  logic       reg_rd_i,
  input  logic [2:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o
);
  localparam int IDW = N_IDS * 8;

  logic sda_s, scl_rise, scl_fall, start_p, stop_p;
  i2cs_linemon #(.SYNC(SYNC)) u_mon (
    .clk, .rst_n, .scl_i, .sda_i, .sda_s, .scl_rise, .scl_fall, .start_p, .stop_p
  );

  i2cs_state_e st_q, st_d;
  logic [3:0]  cnt_q, cnt_d;
  logic [7:0]  sh_q, sh_d;
  logic        rw_q, rw_d, ackok_q, ackok_d, oe_q, oe_d;
  logic [IDW-1:0] id_q, id_d;
  logic        stopf_q, stopf_d;
  logic        hit, busy;

  i2cs_idmatch #(.N_IDS(N_IDS)) u_match (.ids(id_q), .addr7(sh_q[7:1]), .hit);

  logic       rx_push, rx_pop, rx_empty, rx_full;
  logic       tx_push, tx_pop, tx_empty, tx_full;
  logic [7:0] rx_rdata, tx_rdata, tx_byte;

  i2cs_fifo #(.W(8), .DEPTH(FIFO_DEP)) u_rxf (
    .clk, .rst_n, .flush(rx_flush_i), .push(rx_push), .wdata(sh_q),
    .pop(rx_pop), .rdata(rx_rdata), .empty(rx_empty), .full(rx_full)
  );
  i2cs_fifo #(.W(8), .DEPTH(FIFO_DEP)) u_txf (
    .clk, .rst_n, .flush(1'b0), .push(tx_push), .wdata(reg_wdata_i),
    .pop(tx_pop), .rdata(tx_rdata), .empty(tx_empty), .full(tx_full)
  );

  assign busy    = (st_q != ST_IDLE);
  assign tx_byte = tx_empty ? 8'hFF : tx_rdata;
  assign tx_push = reg_wr_i & (reg_addr_i == A_TXD);
  assign rx_pop  = reg_rd_i & (reg_addr_i == A_RXD);

  // Protocol next state
  always_comb begin
    st_d = st_q; cnt_d = cnt_q; sh_d = sh_q; rw_d = rw_q;
    ackok_d = ackok_q; oe_d = oe_q;
    rx_push = 1'b0; tx_pop = 1'b0;
    if (master_mode_i || stop_p) begin
      st_d = ST_IDLE; oe_d = 1'b0;
    end else if (start_p) begin
      st_d = ST_ADDR; cnt_d = '0; oe_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR, ST_RX: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_s};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            if (st_q == ST_ADDR && hit) begin
              st_d = ST_AACK; oe_d = 1'b1; rw_d = sh_q[0];
            end else if (st_q == ST_RX && !rx_full) begin
              st_d = ST_RACK; oe_d = 1'b1; rx_push = 1'b1;
            end else begin
              st_d = ST_IGNORE;
            end
          end
        end
        ST_AACK, ST_TACK: begin
          if (scl_rise) ackok_d = ~sda_s;
          if (scl_fall) begin
            cnt_d = '0;
            if (st_q == ST_AACK && !rw_q) begin
              st_d = ST_RX; oe_d = 1'b0;
            end else if (st_q == ST_AACK || ackok_q) begin
              st_d = ST_TX; sh_d = tx_byte; oe_d = ~tx_byte[7]; tx_pop = 1'b1;
            end else begin
              st_d = ST_IGNORE; oe_d = 1'b0;
            end
          end
        end
        ST_RACK: if (scl_fall) begin
          st_d = ST_RX; cnt_d = '0; oe_d = 1'b0;
        end
        ST_TX: if (scl_fall) begin
          if (cnt_q == 4'd7) begin
            st_d = ST_TACK; oe_d = 1'b0;
          end else begin
            sh_d = {sh_q[6:0], 1'b0}; cnt_d = cnt_q + 4'd1; oe_d = ~sh_q[6];
          end
        end
        default: oe_d = 1'b0;
      endcase
    end
  end

  // Register-side next state
  always_comb begin
    id_d = id_q;
    for (int i = 0; i < N_IDS; i++) begin
      if (reg_wr_i && !busy && reg_addr_i == 3'(i)) id_d[i*8 +: 8] = reg_wdata_i;
    end
    stopf_d = stopf_q;
    if (reg_rd_i && reg_addr_i == A_STAT) stopf_d = 1'b0;
    if (stop_p && !master_mode_i)         stopf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0; rw_q <= 1'b0;
      ackok_q <= 1'b0; oe_q <= 1'b0; id_q <= '0; stopf_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; sh_q <= sh_d; rw_q <= rw_d;
      ackok_q <= ackok_d; oe_q <= oe_d; id_q <= id_d; stopf_q <= stopf_d;
    end
  end

  assign sda_oe_o = oe_q;

  always_comb begin
    reg_rdata_o = 8'h00;
    if (reg_addr_i < 3'(N_IDS))      reg_rdata_o = id_q[reg_addr_i*8 +: 8];
    else if (reg_addr_i == A_RXD)    reg_rdata_o = rx_rdata;
    else if (reg_addr_i == A_STAT)
      reg_rdata_o = {2'b00, tx_full, rw_q, stopf_q, busy, ~rx_empty, tx_empty};
  end
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker #(
  parameter int IDW = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           master_mode_i,
  input logic           rx_flush_i,
  input logic           sda_oe_o,
  input logic           busy,
  input logic           ignoring,
  input logic           stop_p,
  input logic           stopf_q,
  input logic           rx_empty,
  input logic [IDW-1:0] id_q
);
  p_id_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(id_q));

  p_master_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode_i && $past(master_mode_i)) |-> !sda_oe_o);

  p_ignore_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ignoring |-> !sda_oe_o);

  p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush_i |=> rx_empty);

  p_stop_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_p && !master_mode_i) |=> stopf_q);

  p_stop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |=> !busy);
endmodule

bind i2c_quad_id_slave i2cs_checker #(.IDW(N_IDS*8)) u_chk (
  .clk, .rst_n, .master_mode_i, .rx_flush_i, .sda_oe_o,
  .busy, .ignoring(st_q == i2cs_pkg::ST_IGNORE), .stop_p, .stopf_q,
  .rx_empty, .id_q
);

// File: tb/tb_i2c_quad_id_slave.sv
module tb_i2c_quad_id_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic master_mode = 1'b0, flush = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic sda_oe, sda_bus;
  int n_chk = 0, n_bad = 0;

  localparam int Q = 10;

  always #4 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_quad_id_slave dut (
    .clk, .rst_n, .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .master_mode_i(master_mode), .rx_flush_i(flush), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  // {address byte, ack expected}
  localparam logic [8:0] VEC [0:7] = '{
    {8'h50, 1'b1}, {8'hA2, 1'b1}, {8'h3C, 1'b1}, {8'hFE, 1'b1},
    {8'h52, 1'b0}, {8'h00, 1'b0}, {8'h7E, 1'b0}, {8'hA0, 1'b0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic waitq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; waitq(Q); scl_m = 1'b1; waitq(Q);
    sda_m = 1'b0; waitq(Q); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    waitq(Q); sda_m = 1'b0; waitq(Q); scl_m = 1'b1; waitq(Q); sda_m = 1'b1; waitq(Q);
  endtask

  task automatic send_bit(input logic b);
    waitq(Q); sda_m = b; waitq(Q); scl_m = 1'b1; waitq(2 * Q); scl_m = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    waitq(Q); sda_m = 1'b1; waitq(Q); scl_m = 1'b1; waitq(Q);
    b = sda_bus; waitq(Q); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    get_bit(b);
    acked = ~b;
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    send_bit(nack);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog: got 0x00 expected 0x01 (run did not finish)");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic a;
    waitq(3); rst_n = 1'b1; waitq(3);

    // R5 reset value, R11 ID reads zero, address 7 reads zero
    reg_read(3'd6, v); check("R5 status reset", v, 8'h01);
    reg_read(3'd0, v); check("R11 id0 reset", v, 8'h00);
    reg_read(3'd7, v); check("R11 unused addr", v, 8'h00);
    reg_write(3'd6, 8'hFF);
    reg_read(3'd6, v); check("R5 status read-only", v, 8'h01);

    // program IDs (R11), ID1 has bit0 set (R2)
    reg_write(3'd0, 8'h50); reg_write(3'd1, 8'hA3);
    reg_write(3'd2, 8'h3C); reg_write(3'd3, 8'hFE);
    reg_read(3'd1, v); check("R11 id1 readback", v, 8'hA3);

    // R1 R2 R3 address table
    for (int k = 0; k < 8; k++) begin
      bus_start();
      send_byte(VEC[k][8:1], a);
      bus_stop();
      check(VEC[k][0] ? "R1 R2 ack on match" : "R3 nack on miss", 8'(a), 8'(VEC[k][0]));
    end
    reg_read(3'd6, v); check("R10 stop flag after table", v & 8'h0C, 8'h08);
    reg_read(3'd6, v); check("R10 stop flag cleared", v & 8'h08, 8'h00);

    // R8 write transfer
    bus_start();
    send_byte(8'h50, a); check("R8 addr ack", 8'(a), 8'h01);
    send_byte(8'h5A, a); check("R8 data0 ack", 8'(a), 8'h01);
    send_byte(8'hC3, a); check("R8 data1 ack", 8'(a), 8'h01);
    bus_stop();
    reg_read(3'd6, v); check("R10 idle with stop seen", v & 8'h0E, 8'h0A);
    reg_read(3'd5, v); check("R8 first byte", v, 8'h5A);
    reg_read(3'd5, v); check("R8 second byte", v, 8'hC3);
    reg_read(3'd6, v); check("R8 rx drained", v & 8'h02, 8'h00);

    // R3 miss followed by data: ignored
    bus_start();
    send_byte(8'h52, a); check("R3 addr nack", 8'(a), 8'h00);
    send_byte(8'h11, a); check("R3 data nack", 8'(a), 8'h00);
    bus_stop();
    reg_read(3'd6, v); check("R3 nothing received", v & 8'h02, 8'h00);

    // R9 read transfer
    reg_write(3'd4, 8'hA5); reg_write(3'd4, 8'h3C);
    reg_read(3'd6, v); check("R5 tx not empty", v & 8'h01, 8'h00);
    bus_start();
    send_byte(8'h51, a); check("R9 read addr ack", 8'(a), 8'h01);
    reg_read(3'd6, v); check("R5 read dir and busy", v & 8'h14, 8'h14);
    recv_byte(1'b0, v); check("R9 byte0 msb first", v, 8'hA5);
    recv_byte(1'b0, v); check("R9 byte1", v, 8'h3C);
    recv_byte(1'b1, v); check("R9 empty sends FF", v, 8'hFF);
    recv_byte(1'b1, v); check("R9 released after nack", v, 8'hFF);
    bus_stop();

    // R4 ID write blocked mid-transfer
    bus_start();
    send_byte(8'h50, a); check("R4 addr ack", 8'(a), 8'h01);
    reg_write(3'd0, 8'h20);
    bus_stop();
    reg_read(3'd0, v); check("R4 write blocked", v, 8'h50);
    reg_write(3'd0, 8'h20);
    reg_read(3'd0, v); check("R4 write when idle", v, 8'h20);
    reg_read(3'd6, v);

    // R6 master mode
    master_mode = 1'b1; waitq(2);
    bus_start();
    send_byte(8'h20, a); check("R6 no ack in master mode", 8'(a), 8'h00);
    bus_stop();
    reg_read(3'd6, v); check("R6 stop not recorded", v & 8'h0C, 8'h00);
    master_mode = 1'b0; waitq(2);

    // R7 flush
    bus_start();
    send_byte(8'h20, a); send_byte(8'h77, a);
    bus_stop();
    reg_read(3'd6, v); check("R7 data before flush", v & 8'h02, 8'h02);
    @(negedge clk); flush = 1'b1; @(negedge clk); flush = 1'b0;
    reg_read(3'd6, v); check("R7 rx flushed", v & 8'h02, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule